// File: doc/BRIEF.md
# Power-Good Strap Capture and Frequency Mode Select

This block samples two frequency-select strap pins exactly once. The sample is taken when an active-low power-good input is first seen low. The power-good input is asynchronous, so it passes through a synchronizer before it is used. On the clock edge that detects the synchronized low, the block registers both straps. From then on it ignores the power-good input and both straps until the next power-on reset.

The captured straps are decoded into a CPU frequency code. A configuration bit selects between a base table and a doubled table. Once the straps are captured, the pin-direction control turns both shared pins into outputs, so that they can carry reference clocks.

A second configuration bit arms a sticky test mode once the straps have been captured. In test mode, the FS_B strap stays frozen. The FS_A pin goes back to being an input, and its live level selects, with no clock involved, one of two test output states: all outputs high-impedance, or all outputs at the reference frequency divided by N. Only power-on reset leaves test mode.

Top module: `strap_latch_top`

## Requirements
- R1: While `rst_n` is low and after its release, `strap_bits` is 00, `freq_valid` is 0, `freq_code` is 7 (no valid frequency), `pin_dir` is 00 and `test_active`, `test_hiz` and `test_refdiv` are all 0.
- R2: `pwrgd_n` passes through two synchronizer flops. If it is low at rising edges k and k+1, capture happens at edge k+2: `freq_valid` rises and the straps are registered from the FS_A and FS_B levels at that same edge.
- R3: After capture, `strap_bits` and `freq_valid` no longer change, whatever `pwrgd_n`, `fs_a_in` and `fs_b_in` do, until `rst_n` is asserted.
- R4: After capture, and outside test mode, `pin_dir` is 11: bit 0 is the FS_A pin and bit 1 is the FS_B pin, with 1 meaning output. Before capture `pin_dir` is 00.
- R5: Frequency codes are 0=100, 1=133, 2=200, 3=266 and 4=400 MHz, and 7 means none. With `alt_table`=0, the straps (FS_A,FS_B) decode as follows: 00 gives code 0, 01 gives code 2, 10 gives code 1, and 11 gives code 7.
- R6: With `alt_table`=1, the straps (FS_A,FS_B) decode as follows: 00 gives code 2, 01 gives code 4, 10 gives code 3, and 11 gives code 7. The decode follows `alt_table` combinationally at any time after capture.
- R7: Test mode starts at the first rising edge at which the straps are already captured and `test_en` is 1. It does not start before capture. Clearing `test_en` afterwards does not end it.
- R8: In test mode, `pin_dir` is 10, so the FS_A pin is an input again. `test_hiz` follows `fs_a_in` combinationally, `test_refdiv` follows its inverse, and `fs_b_in` has no effect on any output.
- R9: Asserting `rst_n` low ends test mode and re-arms the one-shot capture.
- R10: `strap_bits[0]` holds the captured FS_A level and `strap_bits[1]` the captured FS_B level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrgd_n | input | 1 | Power-good, active low, asynchronous |
| fs_a_in | input | 1 | FS_A strap level |
| fs_b_in | input | 1 | FS_B strap level |
| alt_table | input | 1 | Configuration bit: selects the doubled frequency table |
| test_en | input | 1 | Configuration bit: requests test mode |
| strap_bits | output | 2 | Captured straps, bit 0 FS_A, bit 1 FS_B |
| freq_code | output | 3 | Decoded CPU frequency code |
| freq_valid | output | 1 | Straps have been captured |
| pin_dir | output | 2 | Strap pin direction, 1 = output |
| test_active | output | 1 | Test mode is active |
| test_hiz | output | 1 | Test state: all outputs high-impedance |
| test_refdiv | output | 1 | Test state: all outputs at reference divided by N |

## Verification
The bench places the power-good low edge at known cycles and changes the straps on the cycles around capture. A design with one synchronizer stage too many or too few would then latch the wrong strap values. It also sends a one-cycle power-good glitch, and it keeps toggling power-good and the straps after capture. A design whose capture was not one-shot would pick up the new values.

Test mode is driven in three ways: `test_en` raised before capture, `test_en` raised after capture, and `test_en` dropped afterwards. Against these, a design that entered test mode early, or left it without reset, would show the wrong flags. In test mode, FS_A and FS_B are swept on their own. This catches a design that registered the test-state select, or let FS_B leak into it.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int STRAP_W = 2;

  typedef enum logic [2:0] {
    FREQ_100  = 3'd0,
    FREQ_133  = 3'd1,
    FREQ_200  = 3'd2,
    FREQ_266  = 3'd3,
    FREQ_400  = 3'd4,
    FREQ_NONE = 3'd7
  } freq_code_e;

  // straps[0] = FS_A, straps[1] = FS_B
  function automatic freq_code_e decode_freq(input logic [STRAP_W-1:0] straps,
                                             input logic alt);
    freq_code_e code;
    unique case (straps)
      2'b00:   code = alt ? FREQ_200 : FREQ_100;
      2'b10:   code = alt ? FREQ_400 : FREQ_200;
      2'b01:   code = alt ? FREQ_266 : FREQ_133;
      default: code = FREQ_NONE;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_low,
  input  logic [STRAP_W-1:0] straps_in,
  output logic               captured,
  output logic               cap_event,
  output logic [STRAP_W-1:0] straps_q
);
  assign cap_event = pg_low && !captured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      straps_q <= '0;
    end else if (cap_event) begin
      captured <= 1'b1;
      straps_q <= straps_in;
    end
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic [STRAP_W-1:0] straps_q,
  input  logic               captured,
  input  logic               alt_table,
  output logic [2:0]         freq_code,
  output logic               freq_valid
);
  freq_code_e code;

  always_comb begin
    code = captured ? decode_freq(straps_q, alt_table) : FREQ_NONE;
  end

  assign freq_code  = code;
  assign freq_valid = captured;
endmodule

// File: rtl/strap_test_ctl.sv
module strap_test_ctl
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               captured,
  input  logic               test_en,
  input  logic               fs_a_live,
  output logic               test_active,
  output logic               test_hiz,
  output logic               test_refdiv,
  output logic [STRAP_W-1:0] pin_dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    test_active <= 1'b0;
    else if (captured && test_en)  test_active <= 1'b1;
  end

  // live FS_A, no register on the path
  assign test_hiz    = test_active && fs_a_live;
  assign test_refdiv = test_active && !fs_a_live;

  always_comb begin
    if (!captured)        pin_dir = 2'b00;
    else if (test_active) pin_dir = 2'b10;
    else                  pin_dir = 2'b11;
  end
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_n,
  input  logic       fs_a_in,
  input  logic       fs_b_in,
  input  logic       alt_table,
  input  logic       test_en,
  output logic [1:0] strap_bits,
  output logic [2:0] freq_code,
  output logic       freq_valid,
  output logic [1:0] pin_dir,
  output logic       test_active,
  output logic       test_hiz,
  output logic       test_refdiv
);
  logic pg_sync_n;
  logic pg_low_sync;
  logic captured;
  logic cap_event;
  logic [STRAP_W-1:0] straps_q;

  strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pwrgd_n), .q(pg_sync_n)
  );

  assign pg_low_sync = !pg_sync_n;

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pg_low(pg_low_sync),
    .straps_in({fs_b_in, fs_a_in}),
    .captured(captured), .cap_event(cap_event), .straps_q(straps_q)
  );

  strap_decode u_dec (
    .straps_q(straps_q), .captured(captured), .alt_table(alt_table),
    .freq_code(freq_code), .freq_valid(freq_valid)
  );

  strap_test_ctl u_test (
    .clk(clk), .rst_n(rst_n), .captured(captured), .test_en(test_en),
    .fs_a_live(fs_a_in), .test_active(test_active), .test_hiz(test_hiz),
    .test_refdiv(test_refdiv), .pin_dir(pin_dir)
  );

  assign strap_bits = straps_q;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_a_in,
  input logic       fs_b_in,
  input logic       pg_low_sync,
  input logic       cap_event,
  input logic [1:0] strap_bits,
  input logic [2:0] freq_code,
  input logic       freq_valid,
  input logic [1:0] pin_dir,
  input logic       test_active,
  input logic       test_hiz,
  input logic       test_refdiv
);
  // R1
  uncaptured_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_valid |-> (freq_code == 3'd7 && pin_dir == 2'b00 && !test_active));

  // R2
  capture_on_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_low_sync && !freq_valid) |=> freq_valid);

  // R10
  capture_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_valid) |-> strap_bits == $past({fs_b_in, fs_a_in}));

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |=> ($stable(strap_bits) && freq_valid && !cap_event));

  // R7
  test_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> freq_valid);

  // R9
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |=> test_active);

  // R8
  test_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> (test_hiz == fs_a_in && test_refdiv == !fs_a_in && pin_dir == 2'b10));

  // R4
  pins_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && !test_active) |-> pin_dir == 2'b11);
endmodule

bind strap_latch_top strap_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_a_in(fs_a_in), .fs_b_in(fs_b_in),
  .pg_low_sync(pg_low_sync), .cap_event(cap_event),
  .strap_bits(strap_bits), .freq_code(freq_code), .freq_valid(freq_valid),
  .pin_dir(pin_dir), .test_active(test_active), .test_hiz(test_hiz),
  .test_refdiv(test_refdiv)
);

// File: tb/strap_latch_top_tb.sv
`timescale 1ns/1ps
module strap_latch_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrgd_n = 1'b1;
  logic fs_a_in = 1'b0;
  logic fs_b_in = 1'b0;
  logic alt_table = 1'b0;
  logic test_en = 1'b0;
  logic [1:0] strap_bits;
  logic [2:0] freq_code;
  logic freq_valid;
  logic [1:0] pin_dir;
  logic test_active, test_hiz, test_refdiv;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strap_latch_top dut_i (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .fs_a_in(fs_a_in),
    .fs_b_in(fs_b_in), .alt_table(alt_table), .test_en(test_en),
    .strap_bits(strap_bits), .freq_code(freq_code), .freq_valid(freq_valid),
    .pin_dir(pin_dir), .test_active(test_active), .test_hiz(test_hiz),
    .test_refdiv(test_refdiv)
  );

  // ---------------- behavioural reference model ----------------
  bit pg_hist[$];
  bit m_cap, m_a, m_b, m_test;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_hist.delete();
      pg_hist.push_back(1'b1);
      pg_hist.push_back(1'b1);
      m_cap = 0; m_a = 0; m_b = 0; m_test = 0;
    end else begin
      if (m_cap && test_en) m_test = 1;
      // the level seen two edges back has arrived through the synchronizer
      if (!m_cap && pg_hist[pg_hist.size()-2] == 1'b0) begin
        m_cap = 1; m_a = fs_a_in; m_b = fs_b_in;
      end
      pg_hist.push_back(pwrgd_n);
      if (pg_hist.size() > 4) void'(pg_hist.pop_front());
    end
  end

  function automatic int exp_code(bit cap, bit a, bit b, bit alt);
    int mhz;
    if (!cap) return 7;
    if (a && b) return 7;
    mhz = a ? 133 : (b ? 200 : 100);
    if (alt) mhz = mhz * 2;
    case (mhz)
      100: return 0;
      133: return 1;
      200: return 2;
      266: return 3;
      400: return 4;
      default: return 7;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk(strap_bits == {m_b, m_a}, "R10/R3 strap_bits", strap_bits, {m_b, m_a});
      chk(freq_valid == m_cap, "R2 freq_valid", freq_valid, m_cap);
      chk(freq_code == exp_code(m_cap, m_a, m_b, alt_table), "R5/R6 freq_code",
          freq_code, exp_code(m_cap, m_a, m_b, alt_table));
      chk(pin_dir == (!m_cap ? 2'b00 : (m_test ? 2'b10 : 2'b11)), "R4/R8 pin_dir",
          pin_dir, (!m_cap ? 0 : (m_test ? 2 : 3)));
      chk(test_active == m_test, "R7 test_active", test_active, m_test);
      chk(test_hiz == (m_test && fs_a_in), "R8 test_hiz", test_hiz, m_test && fs_a_in);
      chk(test_refdiv == (m_test && !fs_a_in), "R8 test_refdiv", test_refdiv, m_test && !fs_a_in);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwrgd_n = 1; test_en = 0;
    cyc(3);
    rst_n = 1;
    cyc(2);
  endtask

  task automatic capture_with(input bit a, input bit b);
    do_reset();
    fs_a_in = a; fs_b_in = b;
    pwrgd_n = 0;
    cyc(4);
  endtask

  initial begin
    #1;
    chk(freq_valid == 0 && pin_dir == 0 && freq_code == 7, "R1 in reset", freq_code, 7);
    cyc(3);
    rst_n = 1;
    cyc(2);
    #1;
    chk(strap_bits == 0 && !test_active && !test_hiz && !test_refdiv, "R1 after reset",
        strap_bits, 0);
    fs_a_in = 1; cyc(3); fs_b_in = 1; cyc(3); fs_b_in = 0;
    // R2: exact capture edge
    @(negedge clk); pwrgd_n = 0;
    cyc(2); #1;
    chk(freq_valid == 0, "R2 not yet after two edges", freq_valid, 0);
    fs_a_in = 1; fs_b_in = 0;
    cyc(1); #1;
    chk(freq_valid == 1 && strap_bits == 2'b01, "R2 captured at third edge", strap_bits, 1);
    chk(freq_code == 1, "R5 code 133", freq_code, 1);
    // R3: later activity ignored
    fs_a_in = 0; fs_b_in = 1; pwrgd_n = 1; cyc(4); pwrgd_n = 0; cyc(4);
    #1;
    chk(strap_bits == 2'b01, "R3 frozen straps", strap_bits, 1);
    alt_table = 1; #1;
    chk(freq_code == 3, "R6 code 266", freq_code, 3);
    alt_table = 0;
    // every strap code, both tables
    for (int c = 0; c < 4; c++) begin
      capture_with(c[0], c[1]);
      #1;
      chk(pin_dir == 2'b11, "R4 pins outputs", pin_dir, 3);
      alt_table = 1; cyc(2);
      alt_table = 0; cyc(2);
    end
    // glitch on power good
    do_reset();
    fs_a_in = 0; fs_b_in = 1;
    pwrgd_n = 0; cyc(1); pwrgd_n = 1; cyc(5);
    // R7: test_en before capture does not start test mode
    do_reset();
    test_en = 1; cyc(5); #1;
    chk(test_active == 0, "R7 no test before capture", test_active, 0);
    fs_a_in = 0; fs_b_in = 0; pwrgd_n = 0;
    cyc(4); #1;
    chk(test_active == 1, "R7 test entered", test_active, 1);
    test_en = 0;
    for (int k = 0; k < 8; k++) begin
      fs_a_in = k[0]; fs_b_in = k[1];
      cyc(1);
    end
    // R8: combinational select, FS_B ignored
    fs_a_in = 1; fs_b_in = 0; #0.5;
    chk(test_hiz == 1 && test_refdiv == 0, "R8 hiz async", test_hiz, 1);
    fs_b_in = 1; fs_a_in = 0; #0.5;
    chk(test_hiz == 0 && test_refdiv == 1 && strap_bits == 0, "R8 refdiv async", test_refdiv, 1);
    cyc(3);
    // R9: reset leaves test mode
    do_reset(); #1;
    chk(test_active == 0 && freq_valid == 0, "R9 reset exits test", test_active, 0);
    // test_en raised after capture
    capture_with(1, 1);
    test_en = 1; cyc(3); test_en = 0; cyc(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule